// File: doc/BRIEF.md
# Five-Source Interrupt Controller

This block gathers interrupt requests for a small 8-bit processor and hands the processor one request at a time, together with the address of its handler. There are five sources: two external pins, two timer overflow pulses and a serial flag, which is the OR of the serial port's transmit-done and receive-done levels. Each external pin can be set to react to a low level or to a falling edge. Software enables each source separately and also has one master enable that gates all of them.

A two-level priority register picks the urgency of each source. Within one level, a fixed polling order breaks ties. The controller keeps track of which levels have a handler running. A high-priority request can break into a low-priority handler. A request can never break into a handler at its own level.

On acknowledge, the controller clears the latched flag of the source it served, if that flag belongs to hardware. A return pulse releases the innermost active level. Software reaches the registers through a simple special-register read/write port.

Top module: `irq_ctrl5`

## Requirements
- R1: After reset, every register reads 0, no flag is set, `irq_req` is 0 and `irq_vec` is 0.
- R2: A source can request only when its enable bit is 1 and the master bit is 1. Enable bits sit in register 0: external 0 at bit 0, timer 0 at bit 1, external 1 at bit 2, timer 1 at bit 3, serial at bit 4, master at bit 7. Writing 0x8C lets only external 1 and timer 1 through.
- R3: In level mode (control bit g = 0), the flag of external g is the inverse of the pin as seen through two synchronizing flops. The flag is visible two clock edges after the pin changes and is not latched.
- R4: In edge mode (control bit g = 1), a high-to-low change on the synchronized pin sets a latched flag, which is visible three clock edges after the pin falls. The flag stays set after the pin goes high again. Putting the input back into level mode clears it.
- R5: When a request is acknowledged, the latched flag of the source served is cleared. This applies to an edge-mode external or a timer. A new event in the same cycle keeps the flag set.
- R6: The serial flag (flag bit 4) follows transmit-done OR receive-done and is never cleared by an acknowledge.
- R7: Within a priority level, the winner is the first pending source in this order: external 0, timer 0, external 1, timer 1, serial. The vectors, in the same order, are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. `irq_vec` is 0 when there is no request.
- R8: Priority register bit i set to 1 makes source i high priority. A high request is raised when no high handler is active. A low request is raised only when no handler is active.
- R9: A return pulse releases the high level if it is active, and otherwise the low level.
- R10: Register map. Address 0 is the enable register; bits 5 and 6 read 0. Address 1 is priority, bits 4..0. Address 2 is control, bits 1..0: the trigger mode of external 1 and external 0. Address 3 is the read-only flag register, bits 4..0, in polling order. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses, one per timer |
| ser_ti | input | 1 | Serial transmit-done level |
| ser_ri | input | 1 | Serial receive-done level |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 2 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Handler address of the selected source |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_ret | input | 1 | CPU returns from a handler |

## Verification
The bench measures the exact latency of both trigger paths. A level input that is latched by mistake would keep requesting after the pin rises. An edge flag taken one flop too early or too late would shift the request by a cycle. Several sources are made pending at once so that every polling position is served in turn; a reversed or mis-scaled selector would hand out the wrong vector. A high request is made to break into a low handler, and a request at an equal or lower level is left waiting, to show that a design with a single shared busy bit, or one that returns from the wrong level, either blocks the preemption or lets the waiting request through too early. The serial flag is acknowledged while it is still asserted, which catches a design that clears it.

// File: rtl/irq5_pkg.sv
package irq5_pkg;
  localparam int NSRC     = 5;
  localparam int NEXT     = 2;
  localparam int IDXW     = $clog2(NSRC);
  localparam int MASTER   = 7;
  localparam int SRC_SER  = 4;

  localparam logic [1:0] ADDR_EN  = 2'd0;
  localparam logic [1:0] ADDR_PRI = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_FLG = 2'd3;

  typedef struct packed {
    logic            vld;
    logic            hi;
    logic [IDXW-1:0] idx;
  } pick_t;

  function automatic int ext_src(input int g);
    return 2 * g;
  endfunction

  function automatic int tmr_src(input int g);
    return 2 * g + 1;
  endfunction
endpackage

// File: rtl/irq5_rst_sync.sv
module irq5_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sr_q;
  logic [1:0] sr_d;

  always_comb sr_d = {sr_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sr_q <= '0;
    else           sr_q <= sr_d;
  end

  assign rst_n_out = sr_q[1];
endmodule

// File: rtl/irq5_ext_trig.sv
module irq5_ext_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);
  logic [2:0] smp_q, smp_d;
  logic       lat_q, lat_d;
  logic       fall;

  assign fall = smp_q[2] & ~smp_q[1];

  always_comb begin
    smp_d = {smp_q[1:0], pin};
    lat_d = lat_q;
    if (!edge_mode)  lat_d = 1'b0;
    else if (fall)   lat_d = 1'b1;
    else if (clr)    lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '1;
      lat_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      lat_q <= lat_d;
    end
  end

  assign flag = edge_mode ? lat_q : ~smp_q[1];
endmodule

// File: rtl/irq5_select.sv
module irq5_select
  import irq5_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] pri,
  input  logic            act_hi,
  input  logic            act_lo,
  output pick_t           pick
);
  logic [NSRC-1:0] hi_pend, lo_pend, use_pend;

  always_comb begin
    hi_pend  = pend & pri;
    lo_pend  = pend & ~pri;
    use_pend = (|hi_pend) ? hi_pend : lo_pend;
    pick.idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (use_pend[i]) pick.idx = IDXW'(i);
    end
    pick.hi  = |hi_pend;
    if (|hi_pend)      pick.vld = ~act_hi;
    else if (|lo_pend) pick.vld = ~act_hi & ~act_lo;
    else               pick.vld = 1'b0;
  end
endmodule

// File: rtl/irq_ctrl5.sv
module irq_ctrl5
  import irq5_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_pin,
  input  logic [NEXT-1:0]   tmr_ovf,
  input  logic              ser_ti,
  input  logic              ser_ri,
  input  logic              sfr_wr,
  input  logic [1:0]        sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              irq_ret
);
  localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'((1 << NSRC) - 1) | DATA_W'(1 << MASTER);
  localparam logic [VEC_W-1:0]  VB       = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0]  VS       = VEC_W'(VEC_STEP);

  logic                rst_ni;
  logic [DATA_W-1:0]   en_q, en_d;
  logic [NSRC-1:0]     pri_q, pri_d;
  logic [NEXT-1:0]     mode_q, mode_d;
  logic [NEXT-1:0]     tmr_q, tmr_d;
  logic                act_hi_q, act_hi_d;
  logic                act_lo_q, act_lo_d;
  logic                en_we, pri_we, ctl_we;
  logic [NSRC-1:0]     flag_vec;
  logic [NSRC-1:0]     pend;
  logic                ack_fire;
  pick_t               pick;

  irq5_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_ni));

  assign ack_fire = irq_ack & pick.vld;

  genvar g;
  generate
    for (g = 0; g < NEXT; g++) begin : g_src
      logic ext_flag;
      irq5_ext_trig u_ext (
        .clk      (clk),
        .rst_n    (rst_ni),
        .pin      (ext_pin[g]),
        .edge_mode(mode_q[g]),
        .clr      (ack_fire && (int'(pick.idx) == ext_src(g))),
        .flag     (ext_flag)
      );
      assign flag_vec[ext_src(g)] = ext_flag;
      assign flag_vec[tmr_src(g)] = tmr_q[g];
      always_comb begin
        tmr_d[g] = tmr_ovf[g] | (tmr_q[g] & ~(ack_fire && (int'(pick.idx) == tmr_src(g))));
      end
    end
  endgenerate

  assign flag_vec[SRC_SER] = ser_ti | ser_ri;

  assign pend = flag_vec & en_q[NSRC-1:0] & {NSRC{en_q[MASTER]}};

  irq5_select u_sel (
    .pend  (pend),
    .pri   (pri_q),
    .act_hi(act_hi_q),
    .act_lo(act_lo_q),
    .pick  (pick)
  );

  always_comb begin
    en_we  = sfr_wr && (sfr_addr == ADDR_EN);
    pri_we = sfr_wr && (sfr_addr == ADDR_PRI);
    ctl_we = sfr_wr && (sfr_addr == ADDR_CTL);
    en_d   = sfr_wdata & EN_MASK;
    pri_d  = sfr_wdata[NSRC-1:0];
    mode_d = sfr_wdata[NEXT-1:0];
  end

  always_comb begin
    act_hi_d = act_hi_q;
    act_lo_d = act_lo_q;
    if (irq_ret) begin
      if (act_hi_q) act_hi_d = 1'b0;
      else          act_lo_d = 1'b0;
    end
    if (ack_fire) begin
      if (pick.hi) act_hi_d = 1'b1;
      else         act_lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      pri_q    <= '0;
      mode_q   <= '0;
      tmr_q    <= '0;
      act_hi_q <= 1'b0;
      act_lo_q <= 1'b0;
    end else begin
      if (en_we)  en_q   <= en_d;
      if (pri_we) pri_q  <= pri_d;
      if (ctl_we) mode_q <= mode_d;
      tmr_q    <= tmr_d;
      act_hi_q <= act_hi_d;
      act_lo_q <= act_lo_d;
    end
  end

  always_comb begin
    case (sfr_addr)
      ADDR_EN:  sfr_rdata = en_q;
      ADDR_PRI: sfr_rdata = DATA_W'(pri_q);
      ADDR_CTL: sfr_rdata = DATA_W'(mode_q);
      default:  sfr_rdata = DATA_W'(flag_vec);
    endcase
  end

  assign irq_req = pick.vld;
  assign irq_vec = pick.vld ? (VB + VEC_W'(pick.idx) * VS) : '0;
endmodule

// File: rtl/irq_ctrl5_chk.sv
module irq_ctrl5_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  en,
  input logic [4:0]  flags,
  input logic [1:0]  mode,
  input logic        act_hi,
  input logic        irq_req,
  input logic [15:0] irq_vec,
  input logic        irq_ack,
  input logic        irq_ret,
  input logic [1:0]  tmr_ovf,
  input logic        ser_ti,
  input logic        ser_ri,
  input logic        sfr_wr
);
  AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en[7]); // R2

  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec[2:0] == 3'd3 && irq_vec <= 16'h0023)); // R7

  AST_TMR_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack && irq_vec == 16'h000B && !tmr_ovf[0]) |=> !flags[1]); // R5

  AST_SER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ti || ser_ri) |-> flags[4]); // R6

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && flags[0] && !sfr_wr && !(irq_req && irq_ack && irq_vec == 16'h0003)) |=> flags[0]); // R4

  AST_HI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    act_hi |-> !irq_req); // R8

  AST_RET_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi && irq_ret && !irq_ack) |=> !act_hi); // R9
endmodule

bind irq_ctrl5 irq_ctrl5_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_ni),
  .en     (en_q),
  .flags  (flag_vec),
  .mode   (mode_q),
  .act_hi (act_hi_q),
  .irq_req(irq_req),
  .irq_vec(irq_vec),
  .irq_ack(irq_ack),
  .irq_ret(irq_ret),
  .tmr_ovf(tmr_ovf),
  .ser_ti (ser_ti),
  .ser_ri (ser_ri),
  .sfr_wr (sfr_wr)
);

// File: tb/sim_irq_ctrl5.sv
module sim_irq_ctrl5;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_ti = 1'b0, ser_ri = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [1:0]  sfr_addr = 2'd0;
  logic [7:0]  sfr_wdata = 8'd0;
  logic [7:0]  sfr_rdata;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0, irq_ret = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl5 u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .ser_ti(ser_ti), .ser_ri(ser_ri), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  int    n_chk = 0, n_bad = 0;
  string cur = "R1";
  bit    done = 0;

  // behavioural reference state
  bit [7:0] m_en, m_pri, m_ctl;
  bit [1:0] m_tf, m_ef;
  bit       m_hi, m_lo;
  int       m_rc = 0;
  bit       q0[$], q1[$];

  function automatic void m_reset();
    m_en = 0; m_pri = 0; m_ctl = 0; m_tf = 0; m_ef = 0; m_hi = 0; m_lo = 0;
    q0 = '{1'b1, 1'b1, 1'b1};
    q1 = '{1'b1, 1'b1, 1'b1};
  endfunction

  function automatic bit [4:0] m_flags();
    bit e0, e1;
    e0 = m_ctl[0] ? m_ef[0] : !q0[1];
    e1 = m_ctl[1] ? m_ef[1] : !q1[1];
    return {ser_ti | ser_ri, m_tf[1], e1, m_tf[0], e0};
  endfunction

  function automatic void m_pick(output bit req, output int idx, output bit ishi);
    bit [4:0] pend, hp, lp, use_p;
    pend = m_flags() & m_en[4:0] & {5{m_en[7]}};
    hp = pend & m_pri[4:0];
    lp = pend & ~m_pri[4:0];
    ishi = (hp != 0);
    use_p = ishi ? hp : lp;
    idx = 0;
    for (int i = 4; i >= 0; i--) if (use_p[i]) idx = i;
    if (ishi)        req = !m_hi;
    else if (lp != 0) req = !m_hi && !m_lo;
    else             req = 0;
  endfunction

  function automatic bit [7:0] m_read(input bit [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return m_pri;
      2'd2: return m_ctl;
      default: return {3'b000, m_flags()};
    endcase
  endfunction

  task automatic model_step();
    bit req, ishi, ack, f0, f1;
    int idx;
    if (!rst_n) begin m_reset(); m_rc = 0; return; end
    if (m_rc < 2) begin m_reset(); m_rc++; return; end
    m_pick(req, idx, ishi);
    ack = irq_ack && req;
    f0 = q0[2] && !q0[1];
    f1 = q1[2] && !q1[1];
    if (!m_ctl[0]) m_ef[0] = 0; else if (f0) m_ef[0] = 1; else if (ack && idx == 0) m_ef[0] = 0;
    if (!m_ctl[1]) m_ef[1] = 0; else if (f1) m_ef[1] = 1; else if (ack && idx == 2) m_ef[1] = 0;
    m_tf[0] = tmr_ovf[0] | (m_tf[0] & !(ack && idx == 1));
    m_tf[1] = tmr_ovf[1] | (m_tf[1] & !(ack && idx == 3));
    if (irq_ret) begin if (m_hi) m_hi = 0; else m_lo = 0; end
    if (ack) begin if (ishi) m_hi = 1; else m_lo = 1; end
    if (sfr_wr) begin
      case (sfr_addr)
        2'd0: m_en  = sfr_wdata & 8'h9F;
        2'd1: m_pri = sfr_wdata & 8'h1F;
        2'd2: m_ctl = sfr_wdata & 8'h03;
        default: ;
      endcase
    end
    q0.push_front(ext_pin[0]); void'(q0.pop_back());
    q1.push_front(ext_pin[1]); void'(q1.pop_back());
  endtask

  task automatic chk(input string r, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, got, exp, $time);
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    bit req, ishi;
    int idx;
    model_step();
    #1;
    if (!done) begin
      m_pick(req, idx, ishi);
      chk({cur, " model irq_req"}, irq_req, req);
      chk({cur, " model irq_vec"}, irq_vec, req ? 3 + 8 * idx : 0);
      chk({cur, " model sfr_rdata"}, sfr_rdata, m_read(sfr_addr));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    @(negedge clk); sfr_wr = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 0;
  endtask
  task automatic rd(input bit [1:0] a, input bit [7:0] e, input string r);
    @(negedge clk); sfr_addr = a;
    #1 chk({r, " read"}, sfr_rdata, e);
  endtask
  task automatic see(input bit er, input int ev, input string r);
    @(negedge clk);
    chk({r, " req"}, irq_req, er);
    chk({r, " vec"}, irq_vec, ev);
  endtask
  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask
  task automatic ret();
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
  endtask
  task automatic tpulse(input bit [1:0] m);
    @(negedge clk); tmr_ovf = m;
    @(negedge clk); tmr_ovf = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(4);
    // R1 reset state
    cur = "R1";
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h00, "R1");
    see(0, 0, "R1");
    // R10 register map
    cur = "R10";
    wr(0, 8'hFF); rd(0, 8'h9F, "R10");
    wr(1, 8'hFF); rd(1, 8'h1F, "R10");
    wr(2, 8'hFF); rd(2, 8'h03, "R10");
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);
    // R2 master and individual enables
    cur = "R2";
    wr(0, 8'h0C); tpulse(2'b10);
    rd(3, 8'h08, "R2"); see(0, 0, "R2");
    wr(0, 8'h8C); see(1, 16'h001B, "R2");
    ack(); rd(3, 8'h00, "R5"); see(0, 0, "R5"); ret();
    tpulse(2'b01); rd(3, 8'h02, "R2"); see(0, 0, "R2");
    wr(0, 8'h9F); see(1, 16'h000B, "R2");
    ack(); ret(); see(0, 0, "R9");
    // R3 level trigger
    cur = "R3";
    @(negedge clk); ext_pin[0] = 0;
    see(0, 0, "R3"); see(1, 16'h0003, "R3");
    ack(); rd(3, 8'h01, "R3"); see(0, 0, "R3");
    ret(); see(1, 16'h0003, "R3");
    @(negedge clk); ext_pin[0] = 1;
    see(1, 16'h0003, "R3"); see(0, 0, "R3"); rd(3, 8'h00, "R3");
    // R4 edge trigger
    cur = "R4";
    wr(2, 8'h01);
    @(negedge clk); ext_pin[0] = 0;
    see(0, 0, "R4"); see(0, 0, "R4");
    ext_pin[0] = 1;
    see(1, 16'h0003, "R4");
    tick(4); see(1, 16'h0003, "R4");
    cur = "R5";
    ack(); rd(3, 8'h00, "R5"); ret(); see(0, 0, "R5");
    // R6 serial flag
    cur = "R6";
    @(negedge clk); ser_ti = 1;
    see(1, 16'h0023, "R6");
    ack(); rd(3, 8'h10, "R6"); see(0, 0, "R6");
    ret(); see(1, 16'h0023, "R6");
    @(negedge clk); ser_ti = 0; ser_ri = 1;
    see(1, 16'h0023, "R6");
    @(negedge clk); ser_ri = 0;
    see(0, 0, "R6");
    // R7 polling order
    cur = "R7";
    wr(2, 8'h03);
    @(negedge clk); tmr_ovf = 2'b11; ext_pin[1] = 0;
    @(negedge clk); tmr_ovf = 2'b00;
    tick(3); ext_pin[1] = 1;
    rd(3, 8'h0E, "R7");
    see(1, 16'h000B, "R7"); ack(); ret();
    see(1, 16'h0013, "R7"); ack(); ret();
    see(1, 16'h001B, "R7"); ack(); ret();
    see(0, 0, "R7");
    // R8 / R9 priority nesting
    cur = "R8";
    wr(1, 8'h10);
    tpulse(2'b01); see(1, 16'h000B, "R8");
    ack(); see(0, 0, "R8");
    @(negedge clk); ser_ri = 1;
    see(1, 16'h0023, "R8");
    ack(); tpulse(2'b10); see(0, 0, "R8");
    @(negedge clk); ser_ri = 0;
    cur = "R9";
    ret(); see(0, 0, "R9");
    ret(); see(1, 16'h001B, "R9");
    ack(); ret(); see(0, 0, "R9");
    tick(2);
    summary();
    $finish;
  end
endmodule